// File: doc/BRIEF.md
# Centered Raster Sync Generator

This block produces the line and frame timing for a raster display with a programmable active window that is placed in the middle of the screen. A single select input picks one of two built-in timing sets, one for a 640-pixel-wide native raster and one for an 800-pixel-wide native raster. Each set fixes its sync pulse widths and the minimum blanking on either side of the pulse. The requested horizontal and vertical window sizes shrink the active area. Half of the unused native pixels, or lines, is added to the blanking before the pulse and half to the blanking after it. The total line and frame periods therefore stay close to native, and the picture stays centred.

Outside the block, the active-low sync outputs drive the monitor. The pixel enable and the running pixel address drive a pixel fetch path that reads frame memory in raster order. The horizontal and vertical counts are brought out so that other logic can align with the raster.

Top module: `vsg_centered_sync`

## Requirements
- R1: `res_sel` = 1 selects the narrow timing set and `res_sel` = 0 selects the wide timing set. The narrow set is native 640 x 480, line sync 95 clocks, line blanks 23/47, frame sync 2 lines, frame blanks 14/32. The wide set is native 800 x 600, line sync 120, line blanks 56/63, frame sync 6, frame blanks 37/23. The sizes are parameters, and these are their defaults.
- R2: Let S be the clamped size and d = native − S. The line period is S + (blankA + d/2) + sync + (blankB + d/2), with d/2 truncated. `h_count` runs 0 … period−1 and then returns to 0.
- R3: `hsync_n` is 0 exactly while S + blankA + d/2 ≤ `h_count` < S + blankA + d/2 + sync. It is 1 at all other times.
- R4: `v_count` steps by one in the cycle where `h_count` returns to 0. It wraps to 0 after the frame period, which is formed with the R2 formula from the vertical constants.
- R5: `vsync_n` is 0 over the R3 pattern applied to `v_count` and the vertical values, and is 1 otherwise.
- R6: `pix_en` is 1 only when `h_count` is below the horizontal size and `v_count` is below the vertical size.
- R7: In every cycle with `pix_en` = 1, `pix_addr` equals `v_count` × hsize + `h_count`. In any cycle with `v_count` ≥ vsize and `h_count` ≥ 1, `pix_addr` is 0.
- R8: A requested size above the native size of the selected set behaves as the native size.
- R9: The select and the size inputs are captured during reset and in the last cycle of a frame. A change made mid-frame first takes effect at the next frame's first cycle.
- R10: After reset, `h_count`, `v_count` and `pix_addr` are 0, and `hsync_n` and `vsync_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 1 | Timing set select: 1 = narrow, 0 = wide |
| h_size | input | 10 | Requested active width in pixels |
| v_size | input | 10 | Requested active height in lines |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| pix_en | output | 1 | High inside the active window |
| pix_addr | output | 19 | Raster-order pixel address |
| h_count | output | 11 | Position within the line |
| v_count | output | 11 | Line within the frame |

## Verification
The sync outputs, `pix_en` and `pix_addr` are decoded from registered counters. They are valid in the same cycle as the `h_count`/`v_count` they belong to, so every check compares them against the counts in force in that cycle. A counter change is due one clock edge after the state that causes it. A size or mode change is due at the first cycle after the frame's last cycle. The bench samples at the falling edge and advances its own position model by exactly one cycle per edge. It reloads the model's geometry from the driven inputs at the model's own frame end, so every check lines up with the cycle in which the result is due.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int unsigned CNT_W  = 11;
    localparam int unsigned SIZE_W = 10;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } mode_e;

    // Fixed constants of one axis in one timing set
    typedef struct packed {
        logic [15:0] native;
        logic [15:0] sync;
        logic [15:0] blank_a;
        logic [15:0] blank_b;
    } axis_spec_t;

    // Derived boundaries of one axis, held for a whole frame
    typedef struct packed {
        cnt_t size;
        cnt_t sync_lo;
        cnt_t sync_hi;
        cnt_t last;
    } axis_t;

    function automatic axis_spec_t mk_spec(input int unsigned nat, input int unsigned sy,
                                           input int unsigned ba, input int unsigned bb);
        axis_spec_t s;
        s.native  = 16'(nat);
        s.sync    = 16'(sy);
        s.blank_a = 16'(ba);
        s.blank_b = 16'(bb);
        return s;
    endfunction

    function automatic axis_t axis_calc(input logic [SIZE_W-1:0] req, input axis_spec_t sp);
        axis_t       r;
        int unsigned nat;
        int unsigned sz;
        int unsigned half;
        int unsigned pre;
        nat  = 32'(sp.native);
        sz   = (32'(req) > nat) ? nat : 32'(req);
        half = (nat - sz) / 2;
        pre  = sz + 32'(sp.blank_a) + half;
        r.size    = cnt_t'(sz);
        r.sync_lo = cnt_t'(pre);
        r.sync_hi = cnt_t'(pre + 32'(sp.sync));
        r.last    = cnt_t'(pre + 32'(sp.sync) + 32'(sp.blank_b) + half - 1);
        return r;
    endfunction

endpackage

// File: rtl/vsg_cfg.sv
module vsg_cfg
    import vsg_pkg::*;
#(
    parameter axis_spec_t NAR_H  = '0,
    parameter axis_spec_t NAR_V  = '0,
    parameter axis_spec_t WIDE_H = '0,
    parameter axis_spec_t WIDE_V = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic              mode_sel,
    input  logic [SIZE_W-1:0] h_req,
    input  logic [SIZE_W-1:0] v_req,
    output axis_t             h_cfg,
    output axis_t             v_cfg
);

    mode_e      mode;
    axis_spec_t h_sp;
    axis_spec_t v_sp;

    always_comb begin
        mode = mode_e'(mode_sel);
        h_sp = (mode == MODE_NARROW) ? NAR_H : WIDE_H;
        v_sp = (mode == MODE_NARROW) ? NAR_V : WIDE_V;
    end

    // Geometry is captured only at frame boundaries so a frame never mixes two sets
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            h_cfg <= axis_calc(h_req, h_sp);
            v_cfg <= axis_calc(v_req, v_sp);
        end
    end

    // R9: geometry moves only after reset or a frame end
    a_r9_cfg_frame_only: assert property (@(posedge clk) disable iff (rst)
        ((h_cfg != $past(h_cfg)) || (v_cfg != $past(v_cfg))) |-> $past(frame_end || rst));

endmodule

// File: rtl/vsg_axis.sv
module vsg_axis
    import vsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  axis_t cfg,
    output cnt_t  cnt,
    output logic  at_last,
    output logic  sync_n,
    output logic  active
);

    always_comb begin
        at_last = (cnt >= cfg.last);
        sync_n  = !((cnt >= cfg.sync_lo) && (cnt < cfg.sync_hi));
        active  = (cnt < cfg.size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_last ? '0 : cnt + cnt_t'(1);
        end
    end

    // R2 / R4: the position never leaves the period latched for this frame
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
        cnt <= cfg.last);

endmodule

// File: rtl/vsg_pix_addr.sv
module vsg_pix_addr #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_act,
    input  logic              v_act,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (!v_act) begin
            addr <= '0;
        end else if (h_act) begin
            addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/vsg_centered_sync.sv
module vsg_centered_sync
    import vsg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned NAR_H_ACT  = 640,
    parameter int unsigned NAR_H_SYNC = 95,
    parameter int unsigned NAR_H_BA   = 23,
    parameter int unsigned NAR_H_BB   = 47,
    parameter int unsigned NAR_V_ACT  = 480,
    parameter int unsigned NAR_V_SYNC = 2,
    parameter int unsigned NAR_V_BA   = 14,
    parameter int unsigned NAR_V_BB   = 32,
    parameter int unsigned WID_H_ACT  = 800,
    parameter int unsigned WID_H_SYNC = 120,
    parameter int unsigned WID_H_BA   = 56,
    parameter int unsigned WID_H_BB   = 63,
    parameter int unsigned WID_V_ACT  = 600,
    parameter int unsigned WID_V_SYNC = 6,
    parameter int unsigned WID_V_BA   = 37,
    parameter int unsigned WID_V_BB   = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_sel,
    input  logic [9:0]        h_size,
    input  logic [9:0]        v_size,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              pix_en,
    output logic [ADDR_W-1:0] pix_addr,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count
);

    localparam axis_spec_t NAR_H  = mk_spec(NAR_H_ACT, NAR_H_SYNC, NAR_H_BA, NAR_H_BB);
    localparam axis_spec_t NAR_V  = mk_spec(NAR_V_ACT, NAR_V_SYNC, NAR_V_BA, NAR_V_BB);
    localparam axis_spec_t WIDE_H = mk_spec(WID_H_ACT, WID_H_SYNC, WID_H_BA, WID_H_BB);
    localparam axis_spec_t WIDE_V = mk_spec(WID_V_ACT, WID_V_SYNC, WID_V_BA, WID_V_BB);

    axis_t h_cfg;
    axis_t v_cfg;
    logic  h_last;
    logic  v_last;
    logic  h_act;
    logic  v_act;
    logic  frame_end;

    assign frame_end = h_last && v_last;

    vsg_cfg #(
        .NAR_H (NAR_H),
        .NAR_V (NAR_V),
        .WIDE_H(WIDE_H),
        .WIDE_V(WIDE_V)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .frame_end(frame_end),
        .mode_sel (res_sel),
        .h_req    (h_size),
        .v_req    (v_size),
        .h_cfg    (h_cfg),
        .v_cfg    (v_cfg)
    );

    // Line counter runs every clock
    vsg_axis u_h (
        .clk    (clk),
        .rst    (rst),
        .adv    (1'b1),
        .cfg    (h_cfg),
        .cnt    (h_count),
        .at_last(h_last),
        .sync_n (hsync_n),
        .active (h_act)
    );

    // Frame counter advances on the one-cycle line-end strobe
    vsg_axis u_v (
        .clk    (clk),
        .rst    (rst),
        .adv    (h_last),
        .cfg    (v_cfg),
        .cnt    (v_count),
        .at_last(v_last),
        .sync_n (vsync_n),
        .active (v_act)
    );

    vsg_pix_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .h_act(h_act),
        .v_act(v_act),
        .addr (pix_addr)
    );

    assign pix_en = h_act && v_act;

    // R6: the active window never overlaps either sync pulse
    a_r6_no_sync_in_window: assert property (@(posedge clk) disable iff (rst)
        pix_en |-> (hsync_n && vsync_n));

    // R5: frame sync only changes at the first pixel of a line
    a_r5_vsync_line_aligned: assert property (@(posedge clk) disable iff (rst)
        (vsync_n != $past(vsync_n)) |-> (h_count == '0));

    // R7: consecutive window pixels get consecutive addresses
    a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
        (pix_en && (h_count != '0)) |-> (pix_addr == $past(pix_addr) + ADDR_W'(1)));

    // R10: counters and syncs at their idle values after reset
    a_r10_reset_state: assert property (@(posedge clk)
        $past(rst) |-> ((h_count == '0) && (v_count == '0) && hsync_n && vsync_n));

endmodule

// File: tb/vsg_centered_sync_bench.sv
module vsg_centered_sync_bench;

    // Reduced timing sets so that whole frames are short
    localparam int NH_A = 16, NH_S = 3, NH_1 = 2, NH_2 = 4;
    localparam int NV_A = 6,  NV_S = 2, NV_1 = 1, NV_2 = 2;
    localparam int WH_A = 20, WH_S = 4, WH_1 = 3, WH_2 = 1;
    localparam int WV_A = 8,  WV_S = 1, WV_1 = 2, WV_2 = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_sel = 1'b1;
    logic [9:0]  h_size = 10'd16;
    logic [9:0]  v_size = 10'd6;
    logic        hsync_n;
    logic        vsync_n;
    logic        pix_en;
    logic [18:0] pix_addr;
    logic [10:0] h_count;
    logic [10:0] v_count;

    always #5 clk = ~clk;

    vsg_centered_sync #(
        .ADDR_W(19),
        .NAR_H_ACT(NH_A), .NAR_H_SYNC(NH_S), .NAR_H_BA(NH_1), .NAR_H_BB(NH_2),
        .NAR_V_ACT(NV_A), .NAR_V_SYNC(NV_S), .NAR_V_BA(NV_1), .NAR_V_BB(NV_2),
        .WID_H_ACT(WH_A), .WID_H_SYNC(WH_S), .WID_H_BA(WH_1), .WID_H_BB(WH_2),
        .WID_V_ACT(WV_A), .WID_V_SYNC(WV_S), .WID_V_BA(WV_1), .WID_V_BB(WV_2)
    ) u_vsg_centered_sync (
        .clk(clk), .rst(rst), .res_sel(res_sel), .h_size(h_size), .v_size(v_size),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_en(pix_en), .pix_addr(pix_addr),
        .h_count(h_count), .v_count(v_count)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int eh, ev;
    int hsz, hb1, hsy, hper;
    int vsz, vb1, vsy, vper;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog (R1..all) actual=%0d expected=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic void geo(input int req, input int nat, input int sy, input int b1,
                                input int b2, output int sz, output int ob1, output int osy,
                                output int per);
        int half;
        sz   = (req > nat) ? nat : req;
        half = (nat - sz) / 2;
        ob1  = b1 + half;
        osy  = sy;
        per  = sz + ob1 + sy + b2 + half;
    endfunction

    task automatic load_model();
        if (res_sel) begin
            geo(int'(h_size), NH_A, NH_S, NH_1, NH_2, hsz, hb1, hsy, hper);
            geo(int'(v_size), NV_A, NV_S, NV_1, NV_2, vsz, vb1, vsy, vper);
        end else begin
            geo(int'(h_size), WH_A, WH_S, WH_1, WH_2, hsz, hb1, hsy, hper);
            geo(int'(v_size), WV_A, WV_S, WV_1, WV_2, vsz, vb1, vsy, vper);
        end
    endtask

    // Check the current cycle against the model, then move both one clock on
    task automatic step();
        bit exp_hs, exp_vs, exp_en, lend, fend;
        exp_hs = !((eh >= hsz + hb1) && (eh < hsz + hb1 + hsy));
        exp_vs = !((ev >= vsz + vb1) && (ev < vsz + vb1 + vsy));
        exp_en = (eh < hsz) && (ev < vsz);
        chk(int'(h_count) == eh, "R2 h_count", int'(h_count), eh);
        chk(int'(v_count) == ev, "R4 v_count", int'(v_count), ev);
        chk(hsync_n == exp_hs, "R3 hsync_n", int'(hsync_n), int'(exp_hs));
        chk(vsync_n == exp_vs, "R5 vsync_n", int'(vsync_n), int'(exp_vs));
        chk(pix_en == exp_en, "R6 pix_en", int'(pix_en), int'(exp_en));
        if (exp_en)
            chk(int'(pix_addr) == ev * hsz + eh, "R7 pix_addr in window",
                int'(pix_addr), ev * hsz + eh);
        else if (ev >= vsz && eh >= 1)
            chk(pix_addr == '0, "R7 pix_addr below window", int'(pix_addr), 0);
        lend = (eh == hper - 1);
        fend = lend && (ev == vper - 1);
        eh = lend ? 0 : eh + 1;
        if (lend) ev = (ev == vper - 1) ? 0 : ev + 1;
        if (fend) load_model();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit sel, input int h, input int v);
        @(negedge clk);
        rst = 1'b1;
        res_sel = sel;
        h_size = 10'(h);
        v_size = 10'(v);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        eh = 0;
        ev = 0;
        load_model();
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 16, 6);
        chk(h_count == '0, "R10 h_count after reset", int'(h_count), 0);
        chk(v_count == '0, "R10 v_count after reset", int'(v_count), 0);
        chk(pix_addr == '0, "R10 pix_addr after reset", int'(pix_addr), 0);
        chk(hsync_n == 1'b1, "R10 hsync_n after reset", int'(hsync_n), 1);
        chk(vsync_n == 1'b1, "R10 vsync_n after reset", int'(vsync_n), 1);
    endtask

    // Runs one full frame, measuring line length, sync pulse and lines per frame
    task automatic t_geometry(input bit sel, input int h, input int v, input int exp_line,
                              input int exp_lines, input int exp_lo, input int exp_w,
                              input string tag);
        int n, lines, lo, w;
        bit capd;
        do_reset(sel, h, v);
        n = 0;
        do begin step(); n++; end while (h_count != '0);
        chk(n == exp_line, {tag, " line period"}, n, exp_line);
        lines = 1; lo = -1; w = 0; capd = 1'b0;
        do begin
            if (!hsync_n && !capd) begin
                if (w == 0) lo = int'(h_count);
                w++;
            end else if (w > 0) begin
                capd = 1'b1;
            end
            step();
            if (h_count == '0) lines++;
        end while (v_count != '0);
        chk(lines == exp_lines, {tag, " R4 lines per frame"}, lines, exp_lines);
        chk(lo == exp_lo, {tag, " R3 hsync start"}, lo, exp_lo);
        chk(w == exp_w, {tag, " R3 hsync width"}, w, exp_w);
        repeat (5) step();
    endtask

    task automatic t_midframe_change();
        int n;
        do_reset(1'b1, 16, 6);
        repeat (60) step();
        res_sel = 1'b0;
        h_size = 10'd7;
        v_size = 10'd5;
        do step(); while (!(h_count == '0 && v_count == '0));
        n = 0;
        do begin step(); n++; end while (h_count != '0);
        chk(n == 27, "R9 new geometry from next frame", n, 27);
        repeat (40) step();
    endtask

    initial begin
        t_reset_state();
        t_geometry(1'b1, 16, 6, 25, 11, 18, 3, "R1 narrow full");
        t_geometry(1'b0, 20, 8, 28, 14, 23, 4, "R1 wide full");
        t_geometry(1'b1, 11, 3, 24, 10, 15, 3, "R2 narrow odd centering");
        t_geometry(1'b0, 7, 5, 27, 13, 16, 4, "R2 wide small");
        t_geometry(1'b0, 900, 1000, 28, 14, 23, 4, "R8 clamp");
        t_geometry(1'b1, 0, 0, 25, 11, 10, 3, "R6 empty window");
        t_midframe_change();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule